// File: doc/BRIEF.md
# Periodic Tick and Watchdog Interrupt Unit

This block turns one clock into a periodic time-base tick and a longer watchdog timeout, and reports the timeout on an active-low interrupt request pin. One prescaler feeds both. The tick fires once per prescaler period. A further divider stage, placed after the prescaler, counts those periods and produces the watchdog timeout.

Control comes from eight command inputs. Each one is a decoded pulse, one clock cycle long, coming from an upstream command decoder. The commands start, stop and zero the timer; start, stop and kick the watchdog; and enable or disable the interrupt. Each command acts only on its own resource. Once the interrupt pin goes low on a timeout, it stays low until software kicks the watchdog or disables the interrupt.

Top module: `tbase_wdt_irq`

## Requirements
- R1: After reset the timer, watchdog and interrupt are disabled, both counters hold zero, `irq_n_o` is 1, and `tick_o` and `wdt_tmo_o` are 0. No tick appears until the timer is enabled.
- R2: The prescaler is enabled by `tmr_on_i` at edge E and counts from the following edge. `tick_o` is then high for exactly one cycle after edges E+PRE_DIV, E+2·PRE_DIV and so on.
- R3: While the timer is disabled the prescaler keeps its count and no tick appears. On re-enable, counting continues from the held value.
- R4: `tmr_zero_i` sets the prescaler to zero at the next edge, whether the timer is running or stopped. Zeroing takes priority over a wrap at that same edge.
- R5: While the watchdog is enabled it counts prescaler wraps. Every WDT_DIV-th wrap raises `wdt_tmo_o` for one cycle, in the same cycle as `tick_o`.
- R6: While the watchdog is disabled its divider holds, `wdt_tmo_o` stays 0, and the interrupt latch cannot be set. When it is enabled again, counting resumes from the divider's value.
- R7: A timeout while the interrupt is enabled drives `irq_n_o` low in the same cycle as `wdt_tmo_o`. It stays low through later ticks and timeouts.
- R8: `wdt_kick_i` raises `irq_n_o` at the next edge and zeroes the watchdog divider. It leaves the prescaler unchanged.
- R9: `irq_off_i` raises `irq_n_o` at the next edge. While the interrupt is disabled the pin stays high, and a timeout in that time is not remembered once the interrupt is enabled again.
- R10: Each command changes only its own resource. For example, disabling the interrupt does not stop the watchdog, and kicking the watchdog does not move the tick phase.
- R11: If the on and off commands for the same resource arrive in the same cycle, off wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tmr_on_i | input | 1 | Pulse: enable timer |
| tmr_off_i | input | 1 | Pulse: disable timer |
| tmr_zero_i | input | 1 | Pulse: zero prescaler |
| wdt_on_i | input | 1 | Pulse: enable watchdog |
| wdt_off_i | input | 1 | Pulse: disable watchdog |
| wdt_kick_i | input | 1 | Pulse: zero watchdog divider and release interrupt |
| irq_on_i | input | 1 | Pulse: enable interrupt |
| irq_off_i | input | 1 | Pulse: disable and release interrupt |
| tick_o | output | 1 | One-cycle time-base tick |
| wdt_tmo_o | output | 1 | One-cycle watchdog timeout |
| irq_n_o | output | 1 | Interrupt request, active low, latched |

## Verification
If the prescaler count is wrong, the tick phase shifts. The next `tick_o` pulse then arrives early or late, at most PRE_DIV cycles after the fault. If the watchdog divider is wrong, `wdt_tmo_o` and the low-going edge of `irq_n_o` shift by whole tick periods, and this shows within PRE_DIV·WDT_DIV cycles. If the latch or an enable flag is wrong, the pin has the wrong level on the very next edge, or a timeout from an earlier disabled period shows up after re-enable. For this reason the bench compares all three outputs every cycle against cycle counts measured from each command.

// File: rtl/tbw_pkg.sv
package tbw_pkg;
   // Decoded command strobes, one cycle each
   typedef struct packed {
      logic tmr_on;
      logic tmr_off;
      logic tmr_zero;
      logic wdt_on;
      logic wdt_off;
      logic wdt_kick;
      logic irq_on;
      logic irq_off;
   } cmd_t;

   // Index of each enable flag in the flag bank
   localparam int FLAG_TMR = 0;
   localparam int FLAG_WDT = 1;
   localparam int FLAG_IRQ = 2;
   localparam int NUM_FLAGS = 3;
endpackage

// File: rtl/tbw_flag.sv
module tbw_flag (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     q_o <= 1'b0;
      else if (clr_i)  q_o <= 1'b0;
      else if (set_i)  q_o <= 1'b1;
   end

   p_off_wins_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> !q_o);
   p_on_takes_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i && !clr_i |=> q_o);
endmodule

// File: rtl/tbw_prescaler.sv
module tbw_prescaler #(
   parameter int DIV = 256
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic run_i,
   input  logic zero_i,
   output logic wrap_o
);
   localparam int  CW   = (DIV > 1) ? $clog2(DIV) : 1;
   localparam bit  POW2 = ((DIV & (DIV - 1)) == 0);

   logic [CW-1:0] cnt_q;
   logic          at_top;

   generate
      if (POW2) begin : g_pow2
         assign at_top = &cnt_q;
      end else begin : g_cmp
         assign at_top = (cnt_q == CW'(DIV - 1));
      end
   endgenerate

   assign wrap_o = run_i & at_top & ~zero_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       cnt_q <= '0;
      else if (zero_i)   cnt_q <= '0;
      else if (run_i)    cnt_q <= at_top ? '0 : cnt_q + 1'b1;
   end

   p_hold_when_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run_i && !zero_i |=> $stable(cnt_q));
   p_zero_next_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      zero_i |=> cnt_q == '0);
endmodule

// File: rtl/tbw_divstage.sv
module tbw_divstage #(
   parameter int DIV = 4
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic en_i,
   input  logic step_i,
   input  logic zero_i,
   output logic tmo_o
);
   generate
      if (DIV == 1) begin : g_pass
         assign tmo_o = en_i & step_i & ~zero_i;
      end else begin : g_cnt
         localparam int CW = $clog2(DIV);
         logic [CW-1:0] cnt_q;
         logic          at_top;
         assign at_top = (cnt_q == CW'(DIV - 1));
         assign tmo_o  = en_i & step_i & at_top & ~zero_i;

         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)              cnt_q <= '0;
            else if (zero_i)          cnt_q <= '0;
            else if (en_i && step_i)  cnt_q <= at_top ? '0 : cnt_q + 1'b1;
         end

         p_wdt_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !en_i && !zero_i |=> $stable(cnt_q));
         p_wdt_kick_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            zero_i |=> cnt_q == '0);
      end
   endgenerate
endmodule

// File: rtl/tbw_irq_latch.sv
module tbw_irq_latch (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic en_i,
   input  logic set_i,
   input  logic rel_i,
   output logic irq_n_o
);
   logic pend_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)               pend_q <= 1'b0;
      else if (rel_i || !en_i)   pend_q <= 1'b0;
      else if (set_i)            pend_q <= 1'b1;
   end

   assign irq_n_o = ~pend_q;

   p_irq_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_i && set_i && !rel_i |=> !irq_n_o);
   p_irq_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !irq_n_o && en_i && !rel_i |=> !irq_n_o);
   p_irq_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rel_i |=> irq_n_o);
   p_irq_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> irq_n_o);
endmodule

// File: rtl/tbase_wdt_irq.sv
module tbase_wdt_irq #(
   parameter int PRE_DIV = 256,
   parameter int WDT_DIV = 4
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic tmr_on_i,
   input  logic tmr_off_i,
   input  logic tmr_zero_i,
   input  logic wdt_on_i,
   input  logic wdt_off_i,
   input  logic wdt_kick_i,
   input  logic irq_on_i,
   input  logic irq_off_i,
   output logic tick_o,
   output logic wdt_tmo_o,
   output logic irq_n_o
);
   import tbw_pkg::*;

   generate
      if (PRE_DIV < 2) begin : g_bad_pre
         $error("PRE_DIV must be at least 2");
      end
      if (WDT_DIV < 1) begin : g_bad_wdt
         $error("WDT_DIV must be at least 1");
      end
   endgenerate

   cmd_t cmd;
   assign cmd = '{tmr_on: tmr_on_i, tmr_off: tmr_off_i, tmr_zero: tmr_zero_i,
                  wdt_on: wdt_on_i, wdt_off: wdt_off_i, wdt_kick: wdt_kick_i,
                  irq_on: irq_on_i, irq_off: irq_off_i};

   // Enable flag bank
   logic [NUM_FLAGS-1:0] f_set, f_clr, f_q;
   assign f_set[FLAG_TMR] = cmd.tmr_on;
   assign f_clr[FLAG_TMR] = cmd.tmr_off;
   assign f_set[FLAG_WDT] = cmd.wdt_on;
   assign f_clr[FLAG_WDT] = cmd.wdt_off;
   assign f_set[FLAG_IRQ] = cmd.irq_on;
   assign f_clr[FLAG_IRQ] = cmd.irq_off;

   generate
      for (genvar gi = 0; gi < NUM_FLAGS; gi++) begin : g_flag
         tbw_flag u_flag (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .set_i  (f_set[gi]),
            .clr_i  (f_clr[gi]),
            .q_o    (f_q[gi])
         );
      end
   endgenerate

   logic pre_wrap, wdt_evt;

   tbw_prescaler #(.DIV(PRE_DIV)) u_pre (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (f_q[FLAG_TMR]),
      .zero_i (cmd.tmr_zero),
      .wrap_o (pre_wrap)
   );

   tbw_divstage #(.DIV(WDT_DIV)) u_wdt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (f_q[FLAG_WDT]),
      .step_i (pre_wrap),
      .zero_i (cmd.wdt_kick),
      .tmo_o  (wdt_evt)
   );

   tbw_irq_latch u_irq (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (f_q[FLAG_IRQ]),
      .set_i   (wdt_evt),
      .rel_i   (cmd.wdt_kick | cmd.irq_off),
      .irq_n_o (irq_n_o)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         tick_o    <= 1'b0;
         wdt_tmo_o <= 1'b0;
      end else begin
         tick_o    <= pre_wrap;
         wdt_tmo_o <= wdt_evt;
      end
   end

   p_tick_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_o |=> !tick_o);
   p_tmo_with_tick_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wdt_tmo_o |-> tick_o);
   p_irq_gated_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !f_q[FLAG_IRQ] |-> irq_n_o);
   p_wdt_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !f_q[FLAG_WDT] |=> !wdt_tmo_o);
endmodule

// File: tb/tbase_wdt_irq_bench.sv
`timescale 1ns/1ps
module tbase_wdt_irq_bench;
   localparam int P = 8;
   localparam int W = 4;
   localparam int WP = W * P;

   localparam logic [7:0] TMR_ON  = 8'h01;
   localparam logic [7:0] TMR_OFF = 8'h02;
   localparam logic [7:0] TMR_ZER = 8'h04;
   localparam logic [7:0] WDT_ON  = 8'h08;
   localparam logic [7:0] WDT_OFF = 8'h10;
   localparam logic [7:0] WDT_KCK = 8'h20;
   localparam logic [7:0] IRQ_ON  = 8'h40;
   localparam logic [7:0] IRQ_OFF = 8'h80;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [7:0] cmd = '0;
   logic tick, tmo, irq_n;
   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int base = 0;

   always #2.5 clk = ~clk;

   tbase_wdt_irq #(.PRE_DIV(P), .WDT_DIV(W)) u_tbase_wdt_irq (
      .clk_i(clk), .rst_ni(rst_n),
      .tmr_on_i(cmd[0]), .tmr_off_i(cmd[1]), .tmr_zero_i(cmd[2]),
      .wdt_on_i(cmd[3]), .wdt_off_i(cmd[4]), .wdt_kick_i(cmd[5]),
      .irq_on_i(cmd[6]), .irq_off_i(cmd[7]),
      .tick_o(tick), .wdt_tmo_o(tmo), .irq_n_o(irq_n));

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc - base, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
      cyc++;
   endtask

   task automatic issue(input logic [7:0] m);
      cmd = m;
      step();
      cmd = '0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      step(); step();
      rst_n = 1'b1;
      step();
   endtask

   task automatic wait_tick(output int n);
      n = 0;
      do begin
         step();
         n++;
      end while (!tick && n < 4 * P);
   endtask

   function automatic int on_tick(input int r);
      return (r > 0 && r % P == 0) ? 1 : 0;
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int n;
      int r;
      // R1: reset state and no tick while timer is off
      do_reset();
      chk("R1 irq_n", irq_n, 1);
      chk("R1 tick", tick, 0);
      chk("R1 tmo", tmo, 0);
      for (int i = 0; i < 3 * P; i++) begin
         step();
         chk("R1 idle tick", tick, 0);
      end

      // R2: tick period after enable
      issue(TMR_ON);
      base = cyc;
      for (int i = 1; i <= 3 * P; i++) begin
         step();
         chk("R2 tick", tick, on_tick(cyc - base));
         chk("R2 tmo", tmo, 0);
      end

      // R3: disable holds the count, re-enable resumes
      for (int m = 0; m <= P - 2; m++) begin
         do_reset();
         issue(TMR_ON);
         repeat (m) step();
         issue(TMR_OFF);
         for (int i = 0; i < 2 * P; i++) begin
            step();
            chk("R3 held no tick", tick, 0);
         end
         issue(TMR_ON);
         wait_tick(n);
         chk("R3 resume gap", n, P - 1 - m);
      end

      // R4: zero while running, at the wrap edge, and while stopped
      for (int m = 3; m <= P - 1; m += P - 4) begin
         do_reset();
         issue(TMR_ON);
         repeat (m) step();
         issue(TMR_ZER);
         chk("R4 no wrap on zero", tick, 0);
         wait_tick(n);
         chk("R4 gap after zero", n, P);
      end
      do_reset();
      issue(TMR_ON);
      repeat (3) step();
      issue(TMR_OFF);
      issue(TMR_ZER);
      issue(TMR_ON);
      wait_tick(n);
      chk("R4 zero while stopped", n, P);

      // R5 R7 R8 R10: timeout, latched pin, kick
      do_reset();
      issue(TMR_ON | WDT_ON | IRQ_ON);
      base = cyc;
      for (int i = 1; i <= WP + 1; i++) begin
         step();
         r = cyc - base;
         chk("R5 tick", tick, on_tick(r));
         chk("R5 tmo", tmo, (r == WP) ? 1 : 0);
         chk("R7 irq_n", irq_n, (r < WP) ? 1 : 0);
      end
      issue(WDT_KCK);
      chk("R8 released", irq_n, 1);
      while (cyc - base < 3 * WP + 1) begin
         step();
         r = cyc - base;
         chk("R10 tick phase after kick", tick, on_tick(r));
         chk("R8 tmo restart", tmo, (r % WP == 0 && r >= 2 * WP) ? 1 : 0);
         chk("R7 irq_n stays", irq_n, (r < 2 * WP) ? 1 : 0);
      end

      // R9 R10: interrupt disable, forgotten timeout
      do_reset();
      issue(TMR_ON | WDT_ON | IRQ_ON);
      base = cyc;
      while (cyc - base < WP) step();
      chk("R7 low at timeout", irq_n, 0);
      issue(IRQ_OFF);
      chk("R9 released", irq_n, 1);
      while (cyc - base < 2 * WP + 2) begin
         step();
         r = cyc - base;
         chk("R9 pin high", irq_n, 1);
         chk("R10 wdt runs", tmo, (r == 2 * WP) ? 1 : 0);
      end
      issue(IRQ_ON);
      while (cyc - base < 3 * WP + 1) begin
         step();
         r = cyc - base;
         chk("R9 not remembered", irq_n, (r < 3 * WP) ? 1 : 0);
      end

      // R6: watchdog off, then on later
      do_reset();
      issue(TMR_ON | IRQ_ON);
      base = cyc;
      while (cyc - base < 2 * WP + 3) begin
         step();
         chk("R6 no tmo", tmo, 0);
         chk("R6 pin high", irq_n, 1);
      end
      begin
         int c;
         int tgt;
         c = cyc - base;
         issue(WDT_ON);
         tgt = ((c + 1) / P + W) * P;
         while (cyc - base < tgt + 1) begin
            step();
            r = cyc - base;
            chk("R6 tmo after on", tmo, (r == tgt) ? 1 : 0);
            chk("R6 irq after on", irq_n, (r < tgt) ? 1 : 0);
         end
      end

      // R11: off wins over on
      do_reset();
      issue(TMR_ON | TMR_OFF);
      for (int i = 0; i < 2 * P; i++) begin
         step();
         chk("R11 timer stays off", tick, 0);
      end
      issue(TMR_ON | WDT_ON | IRQ_ON | IRQ_OFF);
      base = cyc;
      while (cyc - base < WP + 1) begin
         step();
         r = cyc - base;
         chk("R11 wdt on", tmo, (r == WP) ? 1 : 0);
         chk("R11 irq stays off", irq_n, 1);
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule